// File: doc/BRIEF.md
# Sticky Edge-Detect Priority Interrupt Inputs

This block carries two urgent interrupt pins straight to the processor core, alongside the general interrupt controller rather than through it. One pin is the non-maskable source. The other is the critical source. Each pin first passes through a synchroniser. It then reaches an edge detector that software sets to react to rising edges, falling edges, or both.

Setting a detector to any active mode locks that channel's setting until the next reset. A detected edge leaves a sticky pending request. The request stays set until the core acknowledges it.

The non-maskable request reaches the core no matter what the core is doing. The critical request is held back while the core signals that a higher exception is in progress. When both are pending, the non-maskable one is offered first. On each accepted entry the block records whether that entry was recoverable. A critical entry is recoverable. A non-maskable entry is not.

Top module: `prio_irq_inputs`

## Requirements
- R1: After reset, both requests are low, `lock_o` is 2'b00, `entry_recov_o` is 1 and both detectors are off.
- R2: A pin transition that matches the channel's mode raises the request after the third rising clock edge that follows it. It is not visible after the second edge. The three edges are two synchroniser stages and one pending register.
- R3: The mode codes are 2'b00 off, 2'b01 rising only, 2'b10 falling only and 2'b11 both. A transition the mode does not select leaves no pending request.
- R4: A configuration write with a nonzero mode sets the channel's lock bit (`lock_o[0]` non-maskable, `lock_o[1]` critical). Later writes to that channel are ignored until reset. A write of 2'b00 to an unlocked channel leaves it unlocked.
- R5: A pending request stays set until it is acknowledged. An accepted acknowledge clears it on the next clock edge.
- R6: `nmi_req_o` follows the non-maskable pending state whatever the value of `exc_mask_i`.
- R7: `crit_req_o` is low while `exc_mask_i` is high. The critical pending state is kept and shows again once the mask drops.
- R8: While a non-maskable request is pending, `crit_req_o` is low. The critical request appears once the non-maskable one is acknowledged.
- R9: `crit_ack_i` has no effect while `crit_req_o` is low. `nmi_ack_i` has no effect while `nmi_req_o` is low.
- R10: `entry_recov_o` goes to 0 after an accepted non-maskable acknowledge and goes to 1 after an accepted critical acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_pin_i | input | 1 | Asynchronous non-maskable pin |
| crit_pin_i | input | 1 | Asynchronous critical pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Channel select: 0 non-maskable, 1 critical |
| cfg_mode_i | input | 2 | Edge mode to write (R3 codes) |
| exc_mask_i | input | 1 | Higher exception in progress; masks the critical request |
| nmi_ack_i | input | 1 | Core accepts the non-maskable request |
| crit_ack_i | input | 1 | Core accepts the critical request |
| nmi_req_o | output | 1 | Non-maskable request to the core |
| crit_req_o | output | 1 | Critical request to the core |
| lock_o | output | 2 | Per-channel configuration lock status |
| entry_recov_o | output | 1 | Last accepted entry was recoverable |

## Verification
Directed sequences do four things. They time a single rising edge against the three-edge latency. They apply the transitions each mode should ignore, and they try to rewrite a locked channel. They also line up both requests together, with and without the mask, which separates a priority fault from a masking fault.

A seeded random phase adds more stimulus. It toggles both pins, the mask, the acknowledges and occasional configuration writes against a cycle model kept in the bench. This exposes faults that only show in mixes, such as an acknowledge that collides with a new edge or one that arrives while the request is blocked.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // True when the current/previous sample pair is an edge selected by mode
  function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return (mode[0] & rise) | (mode[1] & fall);
  endfunction

  // Sticky pending: an accepted acknowledge clears, a new edge sets (set wins)
  function automatic logic pend_next(logic pend, logic take, logic hit);
    return (pend & ~take) | hit;
  endfunction

  // A nonzero mode written to an unlocked channel closes it
  function automatic logic lock_next(logic locked, logic we, edge_mode_e mode);
    return locked | (we & (mode != EDGE_OFF));
  endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_edge_chan.sv
module irq_edge_chan
  import irq_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       take_i,
  output logic       pend_o,
  output logic       lock_o,
  output logic       hit_o
);

  logic       pin_sync;
  logic       pin_prev_q;
  edge_mode_e mode_q;
  logic       lock_q;
  logic       pend_q;
  logic       cfg_accept;

  irq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign cfg_accept = cfg_we_i & ~lock_q;
  assign hit_o      = edge_hit(mode_q, pin_sync, pin_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_prev_q <= 1'b0;
      mode_q     <= EDGE_OFF;
      lock_q     <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      pin_prev_q <= pin_sync;
      if (cfg_accept) mode_q <= edge_mode_e'(cfg_mode_i);
      lock_q     <= lock_next(lock_q, cfg_we_i, edge_mode_e'(cfg_mode_i));
      pend_q     <= pend_next(pend_q, take_i, hit_o);
    end
  end

  assign pend_o = pend_q;
  assign lock_o = lock_q;

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R4
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(mode_q)); // R4
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !take_i) |=> pend_q); // R5
  AST_HIT_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> pend_q); // R2

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_pend_i,
  input  logic crit_pend_i,
  input  logic exc_mask_i,
  input  logic nmi_ack_i,
  input  logic crit_ack_i,
  output logic nmi_req_o,
  output logic crit_req_o,
  output logic nmi_take_o,
  output logic crit_take_o,
  output logic entry_recov_o
);

  logic recov_q;

  // Non-maskable request ignores every mask; critical yields to it and to the mask
  assign nmi_req_o   = nmi_pend_i;
  assign crit_req_o  = crit_pend_i & ~exc_mask_i & ~nmi_pend_i;
  assign nmi_take_o  = nmi_ack_i & nmi_req_o;
  assign crit_take_o = crit_ack_i & crit_req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          recov_q <= 1'b1;
    else if (nmi_take_o)  recov_q <= 1'b0;
    else if (crit_take_o) recov_q <= 1'b1;
  end

  assign entry_recov_o = recov_q;

  AST_NMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> !crit_req_o); // R8
  AST_NMI_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_i && exc_mask_i) |-> nmi_req_o); // R6
  AST_CRIT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_mask_i |-> !crit_req_o); // R7
  AST_RECOV_AFTER_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_take_o |=> !entry_recov_o); // R10
  AST_RECOV_AFTER_CRIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_take_o |=> entry_recov_o); // R10
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_ack_i && !crit_req_o) |-> !crit_take_o); // R9

endmodule

// File: rtl/prio_irq_inputs.sv
module prio_irq_inputs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nmi_pin_i,
  input  logic       crit_pin_i,
  input  logic       cfg_we_i,
  input  logic       cfg_sel_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       exc_mask_i,
  input  logic       nmi_ack_i,
  input  logic       crit_ack_i,
  output logic       nmi_req_o,
  output logic       crit_req_o,
  output logic [1:0] lock_o,
  output logic       entry_recov_o
);

  localparam int NUM_SRC = 2;
  localparam int IDX_NMI = 0;
  localparam int IDX_CRT = 1;

  logic [NUM_SRC-1:0] pins;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] take;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] locks;

  assign pins[IDX_NMI] = nmi_pin_i;
  assign pins[IDX_CRT] = crit_pin_i;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chan
      irq_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_i     (pins[i]),
        .cfg_we_i  (cfg_we_i && (cfg_sel_i == 1'(i))),
        .cfg_mode_i(cfg_mode_i),
        .take_i    (take[i]),
        .pend_o    (pend[i]),
        .lock_o    (locks[i]),
        .hit_o     (hit[i])
      );
    end
  endgenerate

  irq_prio_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .nmi_pend_i   (pend[IDX_NMI]),
    .crit_pend_i  (pend[IDX_CRT]),
    .exc_mask_i   (exc_mask_i),
    .nmi_ack_i    (nmi_ack_i),
    .crit_ack_i   (crit_ack_i),
    .nmi_req_o    (nmi_req_o),
    .crit_req_o   (crit_req_o),
    .nmi_take_o   (take[IDX_NMI]),
    .crit_take_o  (take[IDX_CRT]),
    .entry_recov_o(entry_recov_o)
  );

  assign lock_o = locks;

  AST_CRIT_KEPT_UNDER_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[IDX_CRT] && exc_mask_i) |=> pend[IDX_CRT]); // R7
  AST_NMI_HIT_RAISES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit[IDX_NMI] |=> nmi_req_o); // R2

endmodule

// File: tb/prio_irq_inputs_bench.sv
`timescale 1ns/1ps
module prio_irq_inputs_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_pin = 1'b0, crit_pin = 1'b0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       exc_mask = 1'b0, nmi_ack = 1'b0, crit_ack = 1'b0;
  logic       nmi_req, crit_req, entry_recov;
  logic [1:0] lock;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_inputs u_prio_irq_inputs (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pin_i(nmi_pin), .crit_pin_i(crit_pin),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_mode_i(cfg_mode),
    .exc_mask_i(exc_mask), .nmi_ack_i(nmi_ack), .crit_ack_i(crit_ack),
    .nmi_req_o(nmi_req), .crit_req_o(crit_req), .lock_o(lock),
    .entry_recov_o(entry_recov)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(logic sel, logic [1:0] mode);
    cfg_we = 1'b1; cfg_sel = sel; cfg_mode = mode;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    nmi_pin = 1'b0; crit_pin = 1'b0; exc_mask = 1'b0;
    nmi_ack = 1'b0; crit_ack = 1'b0; cfg_we = 1'b0;
    step(3);
    rst_n = 1'b1;
    step();
  endtask

  // Bench model of expected behaviour, per channel (0 nmi, 1 crit)
  function automatic logic m_hit(logic [1:0] mode, logic cur, logic prev);
    if (mode == 2'b01) return cur && !prev;
    if (mode == 2'b10) return !cur && prev;
    if (mode == 2'b11) return cur != prev;
    return 1'b0;
  endfunction

  logic [1:0] m_s1, m_s2, m_prev, m_pend, m_lock;
  logic [1:0] m_mode [2];
  logic       m_recov;

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 nmi_req", nmi_req, 0);
    chk("R1 crit_req", crit_req, 0);
    chk("R1 lock", lock, 2'b00);
    chk("R1 recov", entry_recov, 1);

    // R4 writing the off code leaves the channel open
    write_cfg(1'b0, 2'b00);
    chk("R4 off write keeps unlocked", lock, 2'b00);
    write_cfg(1'b0, 2'b01);
    chk("R4 nmi locked", lock, 2'b01);
    write_cfg(1'b1, 2'b10);
    chk("R4 both locked", lock, 2'b11);

    // R2 latency of a rising edge on the non-maskable pin
    nmi_pin = 1'b1;
    step(2);
    chk("R2 not yet after 2 edges", nmi_req, 0);
    step();
    chk("R2 visible after 3 edges", nmi_req, 1);

    // R5 sticky until acknowledged; R10 recov cleared by nmi entry
    step(4);
    chk("R5 pending held", nmi_req, 1);
    nmi_ack = 1'b1; step(); nmi_ack = 1'b0;
    chk("R5 cleared by ack", nmi_req, 0);
    chk("R10 nmi entry unrecoverable", entry_recov, 0);

    // R4 locked channel ignores a new mode; R3 rising-only ignores a fall
    write_cfg(1'b0, 2'b10);
    chk("R4 lock unchanged", lock, 2'b11);
    nmi_pin = 1'b0;
    step(5);
    chk("R3 falling edge ignored by rise mode", nmi_req, 0);
    nmi_ack = 1'b1; step(); nmi_ack = 1'b0;
    chk("R9 nmi ack with no request", entry_recov, 0);

    // R3 critical channel is falling-only
    crit_pin = 1'b1;
    step(5);
    chk("R3 rising ignored by fall mode", crit_req, 0);
    crit_pin = 1'b0;
    step(3);
    chk("R3 falling detected", crit_req, 1);

    // R7 masking hides but keeps; R9 ack while masked is ignored
    exc_mask = 1'b1; #1;
    chk("R7 masked", crit_req, 0);
    crit_ack = 1'b1;
    step(3);
    crit_ack = 1'b0;
    chk("R7 still masked", crit_req, 0);
    exc_mask = 1'b0; #1;
    chk("R9 masked ack had no effect", crit_req, 1);
    chk("R10 recov unchanged by ignored ack", entry_recov, 0);
    crit_ack = 1'b1; step(); crit_ack = 1'b0;
    chk("R5 crit cleared", crit_req, 0);
    chk("R10 crit entry recoverable", entry_recov, 1);

    // R8 both pending together, R6 nmi ignores mask
    crit_pin = 1'b1;
    step(4);
    nmi_pin = 1'b1; crit_pin = 1'b0;
    step(3);
    chk("R8 nmi offered", nmi_req, 1);
    chk("R8 crit held back", crit_req, 0);
    exc_mask = 1'b1; #1;
    chk("R6 nmi unmasked", nmi_req, 1);
    exc_mask = 1'b0;
    nmi_ack = 1'b1; step(); nmi_ack = 1'b0;
    chk("R8 crit after nmi ack", crit_req, 1);
    chk("R8 nmi gone", nmi_req, 0);

    // R1 reset clears locks
    do_reset();
    chk("R1 locks cleared by reset", lock, 2'b00);
    chk("R1 requests cleared by reset", {nmi_req, crit_req}, 2'b00);

    // Random phase against the bench model
    void'($urandom(32'h5eed_1234));
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_lock = '0;
    m_mode[0] = 2'b00; m_mode[1] = 2'b00; m_recov = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      logic [1:0] hit, take, pins;
      logic       crit_now;
      if ($urandom_range(3) == 0) nmi_pin = ~nmi_pin;
      if ($urandom_range(3) == 0) crit_pin = ~crit_pin;
      cfg_we   = ($urandom_range(15) == 0);
      cfg_sel  = 1'($urandom_range(1));
      cfg_mode = 2'($urandom_range(3));
      exc_mask = ($urandom_range(2) == 0);
      nmi_ack  = ($urandom_range(1) == 0);
      crit_ack = ($urandom_range(1) == 0);
      pins = {crit_pin, nmi_pin};
      crit_now = m_pend[1] && !exc_mask && !m_pend[0];
      take[0] = nmi_ack && m_pend[0];
      take[1] = crit_ack && crit_now;
      for (int c = 0; c < 2; c++) hit[c] = m_hit(m_mode[c], m_s2[c], m_prev[c]);
      for (int c = 0; c < 2; c++) begin
        m_pend[c] = (m_pend[c] && !take[c]) || hit[c];
        if (cfg_we && cfg_sel == 1'(c) && !m_lock[c]) begin
          m_mode[c] = cfg_mode;
          if (cfg_mode != 2'b00) m_lock[c] = 1'b1;
        end
      end
      if (take[0]) m_recov = 1'b0;
      else if (take[1]) m_recov = 1'b1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
      step();
      chk("R6 random nmi_req", nmi_req, m_pend[0]);
      chk("R7 R8 random crit_req", crit_req, m_pend[1] && !exc_mask && !m_pend[0]);
      chk("R4 random lock", lock, m_lock);
      chk("R10 random recov", entry_recov, m_recov);
    end
    finish_run();
  end

endmodule